// File: doc/BRIEF.md
# NAND Page ECC Single-Bit Corrector

This block settles the outcome of a Hamming check on one 512-byte data block of a NAND page. It takes the 24-bit code read back from the spare area and the 24-bit code freshly computed over the data, and forms their bitwise difference, the syndrome. From the syndrome it reports one of four verdicts: clean, corrected, error inside the code field itself, or uncorrectable. For a correctable error it gives the byte and bit position of the bad data bit. It can also repair that bit in place by reading and rewriting one byte of the page buffer.

A controller pulses `start` with both codes, a policy bit for unprogrammed pages and a repair enable. It then waits for a one-cycle `done` with a 2-bit status. The page buffer sits outside the block. The block reaches it through a one-byte port that has a synchronous read with one cycle of latency. Computing the code over the data stream is left to another block.

Top module: `nand_ecc_corrector`

## Requirements
- R1: The syndrome is `ecc_stored ^ ecc_computed`. Code byte 0 sits in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. An all-zero syndrome gives status 2'b00 (clean) and causes no buffer access.
- R2: When `ecc_stored` is 24'hFFFFFF and `skip_blank` is high, the status is 2'b00 with no buffer access. When `skip_blank` is low, the same codes are classified normally.
- R3: A non-zero syndrome is correctable when every pair of bits (7,6), (5,4), (3,2) and (1,0) differs in each of the three bytes. Its status is then 2'b01 (corrected).
- R4: On status 2'b01, `err_bit` = {byte2[7], byte2[5], byte2[3]}. For any other status, `err_bit` is 0.
- R5: On status 2'b01, `err_byte` = {byte2[1], byte1[7], byte1[5], byte1[3], byte1[1], byte0[7], byte0[5], byte0[3], byte0[1]}. For any other status, `err_byte` is 0.
- R6: With `fix_enable` high, a correctable error makes the block read the byte at `err_byte` in one cycle. In the next cycle it writes back that byte XOR (1 << `err_bit`), exactly once. `done` then appears 3 cycles after the clock edge that takes `start`.
- R7: With `fix_enable` low, a correctable error reports status 2'b01 with both indices and does not touch the buffer.
- R8: A syndrome with exactly one bit set reports status 2'b10 (code-field error) and does not write the buffer.
- R9: Any other non-zero syndrome reports status 2'b11 (uncorrectable) and does not write the buffer.
- R10: `done` is high for exactly one cycle for each accepted start. Without a write-back it is high 1 cycle after the accepting edge.
- R11: A `start` that arrives while an operation is in progress is ignored. It produces no extra `done` and does not change the result.
- R12: After reset, `done`, `status`, `err_byte`, `err_bit`, `mem_rd_en` and `mem_wr_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one check; accepted only when idle |
| ecc_stored | input | 24 | Code read from the spare area |
| ecc_computed | input | 24 | Code computed over the data block |
| skip_blank | input | 1 | Treat an all-ones stored code as an unprogrammed page |
| fix_enable | input | 1 | Apply the repair to the page buffer |
| mem_addr | output | 9 | Byte address into the page buffer |
| mem_rd_en | output | 1 | Read strobe; data returns next cycle |
| mem_rd_data | input | 8 | Read data from the page buffer |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_data | output | 8 | Repaired byte |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 corrected, 10 code-field error, 11 uncorrectable |
| err_byte | output | 9 | Byte index of the bad bit |
| err_bit | output | 3 | Bit index of the bad bit |

## Verification
The checker watches the buffer port on every cycle. It confirms that reads and writes never overlap and that each write follows a read at the same address one cycle earlier. It also checks that a write is always followed by a corrected completion, that no other verdict ever comes after a write, and that `done` never lasts two cycles. The sweeps are needed for everything else. They cover whether the verdict and the index mapping are right for all 4096 single-bit positions and all 24 one-bit syndromes. They also show that the repaired byte holds the intended value, and that blank-page handling, a disabled repair and ignored starts leave the buffer unchanged.

// File: rtl/eccfix_pkg.sv
// Shared types for the NAND ECC corrector.
// Assumes a 2-bit verdict encoding that controllers decode directly.
package eccfix_pkg;

    typedef enum logic [1:0] {
        VERDICT_CLEAN = 2'b00,
        VERDICT_FIXED = 2'b01,
        VERDICT_FIELD = 2'b10,
        VERDICT_FATAL = 2'b11
    } verdict_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_EVAL,
        SEQ_READ,
        SEQ_WRITE
    } seq_state_e;

endpackage

// File: rtl/eccfix_pair_check.sv
// Checks that every adjacent bit pair (2p+1, 2p) of one syndrome byte holds
// two differing values. Purely combinational.
// Assumes BYTE_W is even.
module eccfix_pair_check #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] data_i,
    output logic              pairs_ok_o
);
    localparam int PAIRS = BYTE_W / 2;

    logic [PAIRS-1:0] pair_diff;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        // one pair differs when its two bits disagree
        assign pair_diff[p] = data_i[2*p+1] ^ data_i[2*p];
    end

    assign pairs_ok_o = &pair_diff;

endmodule

// File: rtl/eccfix_decode.sv
// Forms the syndrome from the stored and computed codes and classifies it.
// Also extracts the byte and bit index of a single-bit data error from the
// odd bits of the three syndrome bytes. Purely combinational.
// Assumes a three-byte code where the bits of each byte are interleaved
// as true/complement pairs.
module eccfix_decode
    import eccfix_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [3*BYTE_W-1:0]   ecc_stored_i,
    input  logic [3*BYTE_W-1:0]   ecc_computed_i,
    input  logic                  skip_blank_i,
    output verdict_e              verdict_o,
    output logic [BYTE_W:0]       byte_idx_o,
    output logic [BYTE_W/2-2:0]   bit_idx_o
);
    localparam int ECC_BYTES = 3;
    localparam int ECC_W     = ECC_BYTES * BYTE_W;
    localparam int PAIRS     = BYTE_W / 2;

    logic [ECC_W-1:0]                syndrome;
    logic [ECC_BYTES-1:0]            byte_ok;
    logic [ECC_BYTES-1:0][PAIRS-1:0] odd_bits;
    logic                            blank_page;
    logic                            single_bit;

    assign syndrome   = ecc_stored_i ^ ecc_computed_i;
    assign blank_page = skip_blank_i && (ecc_stored_i == {ECC_W{1'b1}});
    assign single_bit = (syndrome & (syndrome - ECC_W'(1))) == '0;

    for (genvar k = 0; k < ECC_BYTES; k++) begin : g_byte
        logic [BYTE_W-1:0] syn_byte;
        assign syn_byte = syndrome[k*BYTE_W +: BYTE_W];

        eccfix_pair_check #(.BYTE_W(BYTE_W)) u_pair_check (
            .data_i     (syn_byte),
            .pairs_ok_o (byte_ok[k])
        );

        for (genvar p = 0; p < PAIRS; p++) begin : g_odd
            // the odd bit of each pair carries one address bit
            assign odd_bits[k][p] = syn_byte[2*p+1];
        end
    end

    // Byte index: top bit from byte 2, then all of byte 1, then all of byte 0.
    assign byte_idx_o = {odd_bits[2][0], odd_bits[1], odd_bits[0]};
    // Bit index: the upper pairs of byte 2.
    assign bit_idx_o  = odd_bits[2][PAIRS-1:1];

    // classify the syndrome in priority order
    always_comb begin
        if (syndrome == '0) begin
            verdict_o = VERDICT_CLEAN;
        end else if (blank_page) begin
            verdict_o = VERDICT_CLEAN;
        end else if (&byte_ok) begin
            verdict_o = VERDICT_FIXED;
        end else if (single_bit) begin
            verdict_o = VERDICT_FIELD;
        end else begin
            verdict_o = VERDICT_FATAL;
        end
    end

endmodule

// File: rtl/eccfix_seq.sv
// Sequencer: accepts a start when idle, evaluates the verdict, optionally
// performs the read-modify-write of one buffer byte, and publishes the result
// with a one-cycle done pulse.
// Assumes the buffer read has one cycle of latency. Synchronous active-low reset.
module eccfix_seq
    import eccfix_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 fix_q_i,
    input  verdict_e             verdict_i,
    input  logic [BYTE_W:0]      byte_idx_i,
    input  logic [BYTE_W/2-2:0]  bit_idx_i,
    output logic                 capture_o,
    output logic [BYTE_W:0]      mem_addr_o,
    output logic                 mem_rd_en_o,
    input  logic [BYTE_W-1:0]    mem_rd_data_i,
    output logic                 mem_wr_en_o,
    output logic [BYTE_W-1:0]    mem_wr_data_o,
    output logic                 done_o,
    output verdict_e             status_o,
    output logic [BYTE_W:0]      err_byte_o,
    output logic [BYTE_W/2-2:0]  err_bit_o
);
    localparam int ADDR_W = BYTE_W + 1;
    localparam int BIT_W  = BYTE_W / 2 - 1;

    seq_state_e        state;
    logic [ADDR_W-1:0] idx_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] flip_mask;

    assign capture_o     = (state == SEQ_IDLE) && start_i;
    assign mem_addr_o    = idx_q;
    assign mem_rd_en_o   = (state == SEQ_READ);
    assign mem_wr_en_o   = (state == SEQ_WRITE);
    assign flip_mask     = BYTE_W'(1) << bit_q;
    assign mem_wr_data_o = mem_rd_data_i ^ flip_mask;

    // state machine and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            idx_q      <= '0;
            bit_q      <= '0;
            done_o     <= 1'b0;
            status_o   <= VERDICT_CLEAN;
            err_byte_o <= '0;
            err_bit_o  <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state <= SEQ_EVAL;
                    end
                end
                SEQ_EVAL: begin
                    idx_q <= byte_idx_i;
                    bit_q <= bit_idx_i;
                    if ((verdict_i == VERDICT_FIXED) && fix_q_i) begin
                        state <= SEQ_READ;
                    end else begin
                        state    <= SEQ_IDLE;
                        done_o   <= 1'b1;
                        status_o <= verdict_i;
                        if (verdict_i == VERDICT_FIXED) begin
                            err_byte_o <= byte_idx_i;
                            err_bit_o  <= bit_idx_i;
                        end else begin
                            err_byte_o <= '0;
                            err_bit_o  <= '0;
                        end
                    end
                end
                SEQ_READ: begin
                    state <= SEQ_WRITE;
                end
                SEQ_WRITE: begin
                    state      <= SEQ_IDLE;
                    done_o     <= 1'b1;
                    status_o   <= VERDICT_FIXED;
                    err_byte_o <= idx_q;
                    err_bit_o  <= bit_q;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_ecc_corrector.sv
// Top level of the NAND page ECC single-bit corrector.
// It latches the two codes and the policy bits on an accepted start, decodes
// the syndrome, and drives the page-buffer read-modify-write through the
// sequencer.
// Assumes an external 512-byte buffer with a one-cycle synchronous read.
module nand_ecc_corrector
    import eccfix_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [3*BYTE_W-1:0]   ecc_stored,
    input  logic [3*BYTE_W-1:0]   ecc_computed,
    input  logic                  skip_blank,
    input  logic                  fix_enable,
    output logic [BYTE_W:0]       mem_addr,
    output logic                  mem_rd_en,
    input  logic [BYTE_W-1:0]     mem_rd_data,
    output logic                  mem_wr_en,
    output logic [BYTE_W-1:0]     mem_wr_data,
    output logic                  done,
    output logic [1:0]            status,
    output logic [BYTE_W:0]       err_byte,
    output logic [BYTE_W/2-2:0]   err_bit
);
    localparam int ECC_W  = 3 * BYTE_W;
    localparam int ADDR_W = BYTE_W + 1;
    localparam int BIT_W  = BYTE_W / 2 - 1;

    logic [ECC_W-1:0]  stored_q;
    logic [ECC_W-1:0]  computed_q;
    logic              skip_q;
    logic              fix_q;
    logic              capture;
    verdict_e          verdict;
    verdict_e          status_e;
    logic [ADDR_W-1:0] byte_idx;
    logic [BIT_W-1:0]  bit_idx;

    // hold the request operands for the whole operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q   <= '0;
            computed_q <= '0;
            skip_q     <= 1'b0;
            fix_q      <= 1'b0;
        end else if (capture) begin
            stored_q   <= ecc_stored;
            computed_q <= ecc_computed;
            skip_q     <= skip_blank;
            fix_q      <= fix_enable;
        end
    end

    eccfix_decode #(.BYTE_W(BYTE_W)) u_decode (
        .ecc_stored_i   (stored_q),
        .ecc_computed_i (computed_q),
        .skip_blank_i   (skip_q),
        .verdict_o      (verdict),
        .byte_idx_o     (byte_idx),
        .bit_idx_o      (bit_idx)
    );

    eccfix_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .fix_q_i       (fix_q),
        .verdict_i     (verdict),
        .byte_idx_i    (byte_idx),
        .bit_idx_i     (bit_idx),
        .capture_o     (capture),
        .mem_addr_o    (mem_addr),
        .mem_rd_en_o   (mem_rd_en),
        .mem_rd_data_i (mem_rd_data),
        .mem_wr_en_o   (mem_wr_en),
        .mem_wr_data_o (mem_wr_data),
        .done_o        (done),
        .status_o      (status_e),
        .err_byte_o    (err_byte),
        .err_bit_o     (err_bit)
    );

    assign status = status_e;

endmodule

// File: rtl/nand_ecc_corrector_chk.sv
// Port-level protocol checker for nand_ecc_corrector, bound to every instance.
// Assumes the synchronous active-low reset of the design.
module nand_ecc_corrector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] mem_addr,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       done,
    input logic [1:0] status
);
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R6
    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en); // R6
    AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && $stable(mem_addr))); // R6
    AST_WR_ENDS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (done && status == 2'b01)); // R6
    AST_NO_WR_UNFIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'b01) |-> !$past(mem_wr_en)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

bind nand_ecc_corrector nand_ecc_corrector_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .done      (done),
    .status    (status)
);

// File: tb/nand_ecc_corrector_tb_top.sv
module nand_ecc_corrector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] ecc_stored = '0;
    logic [23:0] ecc_computed = '0;
    logic        skip_blank = 1'b0;
    logic        fix_enable = 1'b0;
    logic [8:0]  mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_data;
    logic        mem_wr_en;
    logic [7:0]  mem_wr_data;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;

    int tests = 0;
    int fails = 0;
    int rd_count = 0;
    int wr_count = 0;
    int cycles = 0;
    logic [7:0] ram [512];
    logic [7:0] rd_q;

    always #5 clk = ~clk;

    nand_ecc_corrector dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ecc_stored(ecc_stored), .ecc_computed(ecc_computed),
        .skip_blank(skip_blank), .fix_enable(fix_enable),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
        .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7 + 3);
    endfunction

    // page buffer model: one-cycle read latency, loaded with a pattern in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) ram[i] <= pat(i);
            rd_q <= '0;
        end else begin
            if (mem_wr_en) begin
                ram[mem_addr] <= mem_wr_data;
                wr_count <= wr_count + 1;
            end
            if (mem_rd_en) begin
                rd_q <= ram[mem_addr];
                rd_count <= rd_count + 1;
            end
        end
    end
    assign mem_rd_data = rd_q;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // syndrome that points at byte b, bit t (true/complement pairs per R3-R5)
    function automatic logic [23:0] make_syn(input int b, input int t);
        logic [8:0] bb = 9'(b);
        logic [2:0] tt = 3'(t);
        logic [3:0] odd2 = {tt, bb[8]};
        logic [23:0] s;
        for (int p = 0; p < 4; p++) begin
            s[2*p+1]  = bb[p];     s[2*p]    = ~bb[p];
            s[8+2*p+1] = bb[4+p];  s[8+2*p]  = ~bb[4+p];
            s[16+2*p+1] = odd2[p]; s[16+2*p] = ~odd2[p];
        end
        return s;
    endfunction

    // issue one request and wait for done; lat counts cycles after the accepting edge
    task automatic run_op(input logic [23:0] st, input logic [23:0] cp,
                          input logic sb, input logic fe, output int lat);
        @(negedge clk);
        start = 1'b1; ecc_stored = st; ecc_computed = cp;
        skip_blank = sb; fix_enable = fe;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 20) check(1'b0, "R10 timeout", lat, 3);
    endtask

    task automatic expect_result(input string req, input logic [1:0] st_exp,
                                 input int b_exp, input int t_exp,
                                 input int lat, input int lat_exp);
        check(status == st_exp, req, status, st_exp);
        check(err_byte == 9'(b_exp), {req, " R5 byte"}, err_byte, b_exp);
        check(err_bit == 3'(t_exp), {req, " R4 bit"}, err_bit, t_exp);
        check(lat == lat_exp, {req, " R10 latency"}, lat, lat_exp);
        @(negedge clk);
        check(done == 1'b0, {req, " R10 done width"}, done, 0);
    endtask

    initial begin
        int lat;
        int w0;
        int r0;
        int n_done;
        logic [23:0] base;
        logic [23:0] syn;

        repeat (3) @(negedge clk);
        // R12: reset state
        check(done == 0 && status == 0 && err_byte == 0 && err_bit == 0
              && mem_rd_en == 0 && mem_wr_en == 0, "R12 reset",
              {done, status, err_byte, err_bit, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;

        // R1: zero syndrome for several code values
        for (int i = 0; i < 8; i++) begin
            base = 24'(i * 24'h2A5B3 + 24'h010203);
            w0 = wr_count; r0 = rd_count;
            run_op(base, base, 1'b0, 1'b1, lat);
            expect_result("R1 clean", 2'b00, 0, 0, lat, 1);
            check(wr_count == w0 && rd_count == r0, "R1 no access", wr_count - w0, 0);
        end

        // R2: all-ones stored code with policy set, then with policy clear
        w0 = wr_count;
        run_op(24'hFFFFFF, 24'h123456, 1'b1, 1'b1, lat);
        expect_result("R2 blank", 2'b00, 0, 0, lat, 1);
        check(wr_count == w0, "R2 no write", wr_count - w0, 0);
        run_op(24'hFFFFFF, 24'h000000, 1'b0, 1'b1, lat);
        expect_result("R2 policy off R9", 2'b11, 0, 0, lat, 1);
        run_op(24'hFFFFFF, 24'hFFFFFE, 1'b0, 1'b1, lat);
        expect_result("R2 policy off R8", 2'b10, 0, 0, lat, 1);

        // R3 R4 R5 R6: sweep every byte/bit position, repair then repair back
        for (int b = 0; b < 512; b++) begin
            for (int t = 0; t < 8; t++) begin
                base = 24'(b * 24'h9E37 + t * 24'h1F1);
                syn = make_syn(b, t);
                w0 = wr_count;
                run_op(base ^ syn, base, 1'b0, 1'b1, lat);
                expect_result("R3 R6 fix", 2'b01, b, t, lat, 3);
                check(ram[b] == (pat(b) ^ 8'(1 << t)), "R6 flipped byte",
                      ram[b], pat(b) ^ 8'(1 << t));
                check(wr_count == w0 + 1, "R6 single write", wr_count - w0, 1);
                run_op(base, base ^ syn, 1'b0, 1'b1, lat);
                check(ram[b] == pat(b), "R6 restore", ram[b], pat(b));
            end
        end

        // R7: repair disabled reports indices but leaves the buffer alone
        w0 = wr_count; r0 = rd_count;
        run_op(24'h5A5A5A ^ make_syn(300, 5), 24'h5A5A5A, 1'b0, 1'b0, lat);
        expect_result("R7 nofix", 2'b01, 300, 5, lat, 1);
        check(wr_count == w0 && rd_count == r0, "R7 no access", wr_count - w0, 0);
        check(ram[300] == pat(300), "R7 data", ram[300], pat(300));

        // R8: every one-bit syndrome
        for (int k = 0; k < 24; k++) begin
            w0 = wr_count;
            run_op(24'h3C3C3C ^ (24'h1 << k), 24'h3C3C3C, 1'b0, 1'b1, lat);
            expect_result("R8 field", 2'b10, 0, 0, lat, 1);
            check(wr_count == w0, "R8 no write", wr_count - w0, 0);
        end

        // R9: other non-zero syndromes
        w0 = wr_count;
        run_op(24'h000003, 24'h0, 1'b0, 1'b1, lat);
        expect_result("R9 two bits", 2'b11, 0, 0, lat, 1);
        run_op(make_syn(77, 2) ^ 24'h000001, 24'h0, 1'b0, 1'b1, lat);
        expect_result("R9 broken pair", 2'b11, 0, 0, lat, 1);
        run_op(24'h800001, 24'h0, 1'b0, 1'b1, lat);
        expect_result("R9 far bits", 2'b11, 0, 0, lat, 1);
        check(wr_count == w0, "R9 no write", wr_count - w0, 0);

        // R11: starts while busy are ignored
        w0 = wr_count;
        n_done = 0;
        @(negedge clk);
        start = 1'b1; ecc_stored = make_syn(10, 1); ecc_computed = 24'h0;
        skip_blank = 1'b0; fix_enable = 1'b1;
        @(negedge clk);
        ecc_stored = 24'h000010;
        @(negedge clk);
        if (done) n_done++;
        @(negedge clk);
        if (done) n_done++;
        start = 1'b0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (done) begin
                n_done++;
                check(status == 2'b01 && err_byte == 9'd10 && err_bit == 3'd1,
                      "R11 first result kept", {status, err_byte, err_bit},
                      {2'b01, 9'd10, 3'd1});
            end
        end
        check(n_done == 1, "R11 one done", n_done, 1);
        check(wr_count == w0 + 1, "R11 one write", wr_count - w0, 1);
        check(ram[10] == (pat(10) ^ 8'h02), "R11 data", ram[10], pat(10) ^ 8'h02);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule